// File: doc/BRIEF.md
# Cache Port Bandwidth Occupancy Tracker

This block models how long the two internal ports of a cache stay occupied: the data-array port, used by hits and by line reads for writeback, and the fill port, used when a line returns from the next memory level. Each cycle it may receive one access report and one fill strobe. It turns each report into a number of busy cycles for the port concerned, adds that to a per-port occupancy count, and drains every nonzero count by one per cycle. A scheduler reads the two free outputs and holds back new work while a port is still occupied.

The access report carries a lookup outcome code, the request size in bytes and a flag that says a writeback was issued. A hit costs the request size divided by the port width, rounded up. A miss, or a hit to a line that is reserved but not yet filled, costs one full line transfer only when it issued a writeback. A reservation failure costs nothing. A fill always costs one full line transfer. Three statistic counters record elapsed cycles and the busy cycles of each port. A single clear command zeroes all three.

Top module: `cache_port_meter`

## Requirements
- R1: An accepted report with outcome code 0 (hit) adds ceil(acc_bytes / PORT_BYTES) to the data-port occupancy count. A size of 0 adds nothing.
- R2: Outcome code 1 (hit on a reserved, unfilled line) and code 2 (miss) add LINE_BYTES / PORT_BYTES to the data-port count when acc_wb is 1, and add nothing when acc_wb is 0.
- R3: Outcome code 3 (reservation failure) adds nothing to either port, whatever acc_wb is.
- R4: A cycle with fill_valid high adds LINE_BYTES / PORT_BYTES to the fill-port count. This is independent of any access report in the same cycle.
- R5: At each clock edge the next count of a port is (old count + charge) minus one, or zero if that sum is zero. A count never goes below zero.
- R6: data_free and fill_free are high exactly when the registered count of that port is zero. They change only at a clock edge.
- R7: At each clock edge without stat_clear, stat_avail grows by one. stat_data_busy grows by one if data_free was low before the edge, and stat_fill_busy grows by one if fill_free was low before the edge.
- R8: A clock edge with stat_clear high sets all three statistic counters to zero.
- R9: An occupancy count saturates at 2^OCC_W - 1 before the per-cycle decrement. It never wraps.
- R10: An accepted report with an outcome code of 4 to 7 charges nothing and sets bad_outcome. bad_outcome then stays high until reset.
- R11: After reset both ports are free, all statistic counters read zero and bad_outcome is low.
- R12: While acc_valid is low, the outcome, size and writeback inputs have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_valid | input | 1 | An access report is present this cycle |
| acc_outcome | input | 3 | Lookup outcome code: 0 hit, 1 reserved hit, 2 miss, 3 reservation failure |
| acc_bytes | input | SIZE_W | Request data size in bytes |
| acc_wb | input | 1 | The access issued a writeback |
| fill_valid | input | 1 | A line fill arrives this cycle |
| stat_clear | input | 1 | Zero all statistic counters |
| data_free | output | 1 | Data-array port has no outstanding occupancy |
| fill_free | output | 1 | Fill port has no outstanding occupancy |
| bad_outcome | output | 1 | Sticky flag for an undefined outcome code |
| stat_avail | output | STAT_W | Cycles counted since the last clear |
| stat_data_busy | output | STAT_W | Cycles with the data port occupied |
| stat_fill_busy | output | STAT_W | Cycles with the fill port occupied |

## Verification
The bench builds the block with PORT_BYTES = 24 and LINE_BYTES = 96. A port width that is not a power of two selects the divider variant of the rounding logic. It also makes sizes such as 24, 25 and 127 land on distinct rounding boundaries, and each line transfer costs four cycles. OCC_W = 4 caps the counts at 15, so a short run of back-to-back fills and large hits drives a counter into saturation. SIZE_W = 7 keeps the largest hit charge within that cap. STAT_W = 16 keeps the statistic counters well clear of wrapping over the run.

// File: rtl/cport_pkg.sv
package cport_pkg;

   typedef enum logic [2:0] {
      OC_HIT      = 3'd0,
      OC_HIT_RSV  = 3'd1,
      OC_MISS     = 3'd2,
      OC_RSV_FAIL = 3'd3
   } outcome_e;

   localparam int OUTCOME_W = 3;

   function automatic logic outcome_known(input logic [OUTCOME_W-1:0] code);
      return (code <= OUTCOME_W'(OC_RSV_FAIL));
   endfunction

   function automatic logic is_pow2(input int value);
      return (value > 0) && ((value & (value - 1)) == 0);
   endfunction

endpackage

// File: rtl/cport_charge_calc.sv
module cport_charge_calc
   import cport_pkg::*;
#(
   parameter int LINE_BYTES = 128,
   parameter int PORT_BYTES = 32,
   parameter int SIZE_W     = 8,
   parameter int OCC_W      = 8
) (
   input  logic                 acc_valid,
   input  logic [OUTCOME_W-1:0] acc_outcome,
   input  logic [SIZE_W-1:0]    acc_bytes,
   input  logic                 acc_wb,
   input  logic                 fill_valid,
   output logic [OCC_W-1:0]     data_chg,
   output logic [OCC_W-1:0]     fill_chg,
   output logic                 bad_code
);

   localparam int QW       = SIZE_W + 1;
   localparam int LINE_CH  = LINE_BYTES / PORT_BYTES;
   localparam int SHIFT    = $clog2(PORT_BYTES);

   logic [QW-1:0]    padded;
   logic [QW-1:0]    hit_cycles;
   logic             known;

   assign padded = {1'b0, acc_bytes} + QW'(PORT_BYTES - 1);

   generate
      if (is_pow2(PORT_BYTES)) begin : g_shift_ceil
         assign hit_cycles = padded >> SHIFT;
      end else begin : g_div_ceil
         assign hit_cycles = padded / QW'(PORT_BYTES);
      end
   endgenerate

   assign known = outcome_known(acc_outcome);

   always_comb begin
      data_chg = '0;
      if (acc_valid && known) begin
         unique case (outcome_e'(acc_outcome))
            OC_HIT:               data_chg = OCC_W'(hit_cycles);
            OC_HIT_RSV, OC_MISS:  data_chg = acc_wb ? OCC_W'(LINE_CH) : '0;
            OC_RSV_FAIL:          data_chg = '0;
            default:              data_chg = '0;
         endcase
      end
   end

   assign fill_chg = fill_valid ? OCC_W'(LINE_CH) : '0;
   assign bad_code = acc_valid && !known;

endmodule

// File: rtl/cport_occ_counter.sv
module cport_occ_counter #(
   parameter int OCC_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [OCC_W-1:0] charge,
   output logic             idle
);

   localparam logic [OCC_W:0] CAP = {1'b0, {OCC_W{1'b1}}};

   logic [OCC_W-1:0] count_q;
   logic [OCC_W:0]   raw_sum;
   logic [OCC_W-1:0] capped;
   logic [OCC_W-1:0] count_d;

   assign raw_sum = {1'b0, count_q} + {1'b0, charge};
   assign capped  = (raw_sum > CAP) ? CAP[OCC_W-1:0] : raw_sum[OCC_W-1:0];
   assign count_d = (capped == '0) ? '0 : capped - 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_q <= '0;
      end else begin
         count_q <= count_d;
      end
   end

   assign idle = (count_q == '0);

endmodule

// File: rtl/cport_util_stats.sv
module cport_util_stats #(
   parameter int STAT_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              data_busy,
   input  logic              fill_busy,
   output logic [STAT_W-1:0] avail,
   output logic [STAT_W-1:0] data_busy_cnt,
   output logic [STAT_W-1:0] fill_busy_cnt
);

   localparam int NCNT = 3;

   logic [NCNT-1:0]   bump;
   logic [STAT_W-1:0] cnt_q [NCNT];

   assign bump = {fill_busy, data_busy, 1'b1};

   generate
      for (genvar i = 0; i < NCNT; i++) begin : g_cnt
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q[i] <= '0;
            end else if (clear) begin
               cnt_q[i] <= '0;
            end else if (bump[i]) begin
               cnt_q[i] <= cnt_q[i] + 1'b1;
            end
         end
      end
   endgenerate

   assign avail         = cnt_q[0];
   assign data_busy_cnt = cnt_q[1];
   assign fill_busy_cnt = cnt_q[2];

endmodule

// File: rtl/cache_port_meter.sv
module cache_port_meter
   import cport_pkg::*;
#(
   parameter int LINE_BYTES = 128,
   parameter int PORT_BYTES = 32,
   parameter int SIZE_W     = 8,
   parameter int OCC_W      = 8,
   parameter int STAT_W     = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_valid,
   input  logic [2:0]        acc_outcome,
   input  logic [SIZE_W-1:0] acc_bytes,
   input  logic              acc_wb,
   input  logic              fill_valid,
   input  logic              stat_clear,
   output logic              data_free,
   output logic              fill_free,
   output logic              bad_outcome,
   output logic [STAT_W-1:0] stat_avail,
   output logic [STAT_W-1:0] stat_data_busy,
   output logic [STAT_W-1:0] stat_fill_busy
);

   localparam int LINE_CH    = LINE_BYTES / PORT_BYTES;
   localparam int MAX_HIT_CH = ((1 << SIZE_W) - 1 + PORT_BYTES - 1) / PORT_BYTES;
   localparam int OCC_MAX    = (1 << OCC_W) - 1;

   generate
      if (PORT_BYTES < 1 || LINE_BYTES < PORT_BYTES) begin : g_bad_width
         $error("cache_port_meter: PORT_BYTES must be at least 1 and no larger than LINE_BYTES");
      end
      if ((LINE_BYTES % PORT_BYTES) != 0) begin : g_bad_multiple
         $error("cache_port_meter: LINE_BYTES must be a whole multiple of PORT_BYTES");
      end
      if (PORT_BYTES > (1 << SIZE_W)) begin : g_bad_size
         $error("cache_port_meter: SIZE_W too narrow for PORT_BYTES");
      end
      if (OCC_MAX < 2 * LINE_CH || OCC_MAX < MAX_HIT_CH) begin : g_bad_occ
         $error("cache_port_meter: OCC_W cannot hold two line charges or the largest hit");
      end
      if (STAT_W < 2) begin : g_bad_stat
         $error("cache_port_meter: STAT_W must be at least 2");
      end
   endgenerate

   logic [OCC_W-1:0] data_chg;
   logic [OCC_W-1:0] fill_chg;
   logic             bad_code;
   logic             bad_q;

   cport_charge_calc #(
      .LINE_BYTES (LINE_BYTES),
      .PORT_BYTES (PORT_BYTES),
      .SIZE_W     (SIZE_W),
      .OCC_W      (OCC_W)
   ) u_calc (
      .acc_valid   (acc_valid),
      .acc_outcome (acc_outcome),
      .acc_bytes   (acc_bytes),
      .acc_wb      (acc_wb),
      .fill_valid  (fill_valid),
      .data_chg    (data_chg),
      .fill_chg    (fill_chg),
      .bad_code    (bad_code)
   );

   cport_occ_counter #(.OCC_W(OCC_W)) u_data_occ (
      .clk    (clk),
      .rst_n  (rst_n),
      .charge (data_chg),
      .idle   (data_free)
   );

   cport_occ_counter #(.OCC_W(OCC_W)) u_fill_occ (
      .clk    (clk),
      .rst_n  (rst_n),
      .charge (fill_chg),
      .idle   (fill_free)
   );

   cport_util_stats #(.STAT_W(STAT_W)) u_stats (
      .clk           (clk),
      .rst_n         (rst_n),
      .clear         (stat_clear),
      .data_busy     (!data_free),
      .fill_busy     (!fill_free),
      .avail         (stat_avail),
      .data_busy_cnt (stat_data_busy),
      .fill_busy_cnt (stat_fill_busy)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bad_q <= 1'b0;
      end else if (bad_code) begin
         bad_q <= 1'b1;
      end
   end

   assign bad_outcome = bad_q;

endmodule

// File: rtl/cport_meter_chk.sv
module cport_meter_chk #(
   parameter int LINE_BYTES = 128,
   parameter int PORT_BYTES = 32,
   parameter int SIZE_W     = 8,
   parameter int STAT_W     = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              acc_valid,
   input logic [2:0]        acc_outcome,
   input logic [SIZE_W-1:0] acc_bytes,
   input logic              acc_wb,
   input logic              fill_valid,
   input logic              stat_clear,
   input logic              data_free,
   input logic              fill_free,
   input logic              bad_outcome,
   input logic [STAT_W-1:0] stat_avail,
   input logic [STAT_W-1:0] stat_data_busy,
   input logic [STAT_W-1:0] stat_fill_busy
);

   localparam int  LINE_CH  = LINE_BYTES / PORT_BYTES;
   localparam bit  MULTI_CH = (LINE_CH > 1);

   // R2: a writeback-producing miss occupies the data port past the next edge
   p_miss_wb_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (MULTI_CH && acc_valid && acc_outcome == 3'd2 && acc_wb) |=> !data_free);

   // R3: a reservation failure leaves a free data port free
   p_rsvfail_free_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_outcome == 3'd3 && data_free) |=> data_free);

   // R4: a fill occupies the fill port past the next edge
   p_fill_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (MULTI_CH && fill_valid) |=> !fill_free);

   // R7: cycle counter advances by exactly one without clear
   p_avail_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !stat_clear |=> stat_avail == STAT_W'($past(stat_avail) + 1'b1));

   // R7: a free data port adds no busy cycle
   p_busy_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!stat_clear && data_free) |=> $stable(stat_data_busy));

   // R8: clear zeroes every statistic
   p_clear_all_r8: assert property (@(posedge clk) disable iff (!rst_n)
      stat_clear |=> (stat_avail == '0 && stat_data_busy == '0 && stat_fill_busy == '0));

   // R10: undefined code raises the flag
   p_bad_sets_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_outcome > 3'd3) |=> bad_outcome);

   // R10: the flag is sticky
   p_bad_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      bad_outcome |=> bad_outcome);

   // R12: no report, no new data-port occupancy
   p_idle_free_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (!acc_valid && data_free) |=> data_free);

endmodule

bind cache_port_meter cport_meter_chk #(
   .LINE_BYTES (LINE_BYTES),
   .PORT_BYTES (PORT_BYTES),
   .SIZE_W     (SIZE_W),
   .STAT_W     (STAT_W)
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .acc_valid      (acc_valid),
   .acc_outcome    (acc_outcome),
   .acc_bytes      (acc_bytes),
   .acc_wb         (acc_wb),
   .fill_valid     (fill_valid),
   .stat_clear     (stat_clear),
   .data_free      (data_free),
   .fill_free      (fill_free),
   .bad_outcome    (bad_outcome),
   .stat_avail     (stat_avail),
   .stat_data_busy (stat_data_busy),
   .stat_fill_busy (stat_fill_busy)
);

// File: tb/tb_cache_port_meter.sv
`timescale 1ns/1ps
module tb_cache_port_meter;

   localparam int LINE_BYTES = 96;
   localparam int PORT_BYTES = 24;
   localparam int SIZE_W     = 7;
   localparam int OCC_W      = 4;
   localparam int STAT_W     = 16;
   localparam int OCC_CAP    = (1 << OCC_W) - 1;
   localparam int LINE_CH    = LINE_BYTES / PORT_BYTES;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              acc_valid = 1'b0;
   logic [2:0]        acc_outcome = 3'd0;
   logic [SIZE_W-1:0] acc_bytes = '0;
   logic              acc_wb = 1'b0;
   logic              fill_valid = 1'b0;
   logic              stat_clear = 1'b0;
   logic              data_free;
   logic              fill_free;
   logic              bad_outcome;
   logic [STAT_W-1:0] stat_avail;
   logic [STAT_W-1:0] stat_data_busy;
   logic [STAT_W-1:0] stat_fill_busy;

   int checks = 0;
   int failures = 0;
   bit finished = 0;

   // reference model state
   int m_docc = 0, m_focc = 0, m_avail = 0, m_dbusy = 0, m_fbusy = 0;
   bit m_err = 0;

   always #2 clk = ~clk;   // 250 MHz

   cache_port_meter #(
      .LINE_BYTES (LINE_BYTES),
      .PORT_BYTES (PORT_BYTES),
      .SIZE_W     (SIZE_W),
      .OCC_W      (OCC_W),
      .STAT_W     (STAT_W)
   ) dut (
      .clk            (clk),
      .rst_n          (rst_n),
      .acc_valid      (acc_valid),
      .acc_outcome    (acc_outcome),
      .acc_bytes      (acc_bytes),
      .acc_wb         (acc_wb),
      .fill_valid     (fill_valid),
      .stat_clear     (stat_clear),
      .data_free      (data_free),
      .fill_free      (fill_free),
      .bad_outcome    (bad_outcome),
      .stat_avail     (stat_avail),
      .stat_data_busy (stat_data_busy),
      .stat_fill_busy (stat_fill_busy)
   );

   task automatic check(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
      end
   endtask

   task automatic compare_all(input string req);
      check(req, "data_free",      int'(data_free),      int'(m_docc == 0));
      check(req, "fill_free",      int'(fill_free),      int'(m_focc == 0));
      check(req, "bad_outcome",    int'(bad_outcome),    int'(m_err));
      check(req, "stat_avail",     int'(stat_avail),     m_avail);
      check(req, "stat_data_busy", int'(stat_data_busy), m_dbusy);
      check(req, "stat_fill_busy", int'(stat_fill_busy), m_fbusy);
   endtask

   function automatic int drain(input int occ, input int chg);
      int s = occ + chg;
      if (s > OCC_CAP) s = OCC_CAP;
      return (s > 0) ? s - 1 : 0;
   endfunction

   // one clock: drive at negedge, model next state, compare at next negedge
   task automatic step(input bit v, input int oc, input int sz, input bit wb,
                       input bit fl, input bit clr, input string req);
      int dch = 0;
      int fch = 0;
      acc_valid   = v;
      acc_outcome = 3'(oc);
      acc_bytes   = SIZE_W'(sz);
      acc_wb      = wb;
      fill_valid  = fl;
      stat_clear  = clr;
      if (v) begin
         if (oc == 0) dch = (sz + PORT_BYTES - 1) / PORT_BYTES;
         else if (oc == 1 || oc == 2) dch = wb ? LINE_CH : 0;
         else if (oc == 3) dch = 0;
         else m_err = 1;
      end
      if (fl) fch = LINE_CH;
      if (clr) begin
         m_avail = 0; m_dbusy = 0; m_fbusy = 0;
      end else begin
         m_avail++;
         if (m_docc != 0) m_dbusy++;
         if (m_focc != 0) m_fbusy++;
      end
      m_docc = drain(m_docc, dch);
      m_focc = drain(m_focc, fch);
      @(posedge clk);
      @(negedge clk);
      compare_all(req);
   endtask

   task automatic idle(input int n, input string req);
      for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, req);
   endtask

   initial begin
      #200000;
      if (!finished) begin
         finished = 1;
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      compare_all("R11");            // reset state
      rst_n = 1'b1;

      // R12: report fields ignored while acc_valid low
      step(0, 0, 127, 1, 0, 0, "R12");
      step(0, 2, 100, 1, 0, 0, "R12");
      step(0, 6, 50, 0, 0, 0, "R12");

      // R1: ceiling of size over port width
      step(1, 0, 25, 0, 0, 0, "R1");   // 2 cycles
      idle(3, "R1");
      step(1, 0, 24, 0, 0, 0, "R1");   // 1 cycle, drains same edge
      step(1, 0, 0, 0, 0, 0, "R1");    // nothing
      step(1, 0, 127, 0, 0, 0, "R1");  // 6 cycles
      idle(7, "R1");
      step(1, 0, 49, 1, 0, 0, "R1");   // 3 cycles, wb ignored on hit
      idle(4, "R1");

      // R2: miss / reserved hit
      step(1, 2, 10, 1, 0, 0, "R2");
      idle(5, "R2");
      step(1, 2, 10, 0, 0, 0, "R2");
      step(1, 1, 90, 1, 0, 0, "R2");
      idle(5, "R2");
      step(1, 1, 90, 0, 0, 0, "R2");
      idle(1, "R2");

      // R3: reservation failure charges nothing
      step(1, 3, 127, 1, 0, 0, "R3");
      step(1, 3, 5, 0, 0, 0, "R3");
      idle(1, "R3");

      // R4: fill port charge, alongside an access
      step(0, 0, 0, 0, 1, 0, "R4");
      idle(5, "R4");
      step(1, 0, 48, 0, 1, 0, "R4");
      idle(5, "R4");

      // R5: overlapping charges accumulate
      step(1, 0, 127, 0, 0, 0, "R5");
      step(1, 0, 60, 0, 0, 0, "R5");
      step(1, 2, 0, 1, 1, 0, "R5");
      idle(14, "R5");

      // R9: saturation
      for (int i = 0; i < 6; i++) step(1, 0, 127, 0, 1, 0, "R9");
      idle(17, "R9");

      // R6 / R7: busy accounting across partial occupancy
      step(1, 0, 30, 0, 0, 0, "R6");
      step(0, 0, 0, 0, 0, 0, "R6");
      step(0, 0, 0, 0, 1, 0, "R7");
      idle(6, "R7");

      // R8: clear while busy
      step(1, 2, 0, 1, 1, 1, "R8");
      idle(2, "R8");
      step(0, 0, 0, 0, 0, 1, "R8");
      idle(4, "R8");

      // R10: undefined outcome codes
      step(1, 5, 100, 1, 0, 0, "R10");
      step(0, 0, 0, 0, 0, 0, "R10");
      step(1, 7, 127, 0, 0, 0, "R10");
      idle(2, "R10");

      if (!finished) begin
         finished = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule